// File: doc/BRIEF.md
# Iterative RSSI Power Estimator

This block turns a stream of unsigned sample magnitudes into a received-signal-strength figure. Over a fixed window of valid samples it builds the sum of squares (the energy). It then finds the mean power with a divider that makes one trial per clock, finds the integer RMS value with a square-root search that also makes one trial per clock, and converts the RMS value to decibels through a 256-entry table addressed directly by the RMS result.

The results are held at the outputs until the next window completes. A single-cycle done flag marks the cycle in which the decibel value becomes valid. A new measurement starts on reset, or when the all-ones sample arrives with its valid strobe while the block is holding a result. The serial front end that delivers the samples lies outside this block.

Top module: `rssi_power_est`

## Requirements
- R1: After synchronous active-low reset, energy_o, power_o, rms_o and db_o read 0, done_o is low, and the block is collecting a new window.
- R2: While collecting, each cycle with sample_vld_i high adds sample_i squared to the energy and counts one sample; cycles with sample_vld_i low are ignored.
- R3: The window is WINDOW valid samples (1000 by default); the sample that completes it ends collection, and energy_o then equals the sum of the squares of exactly those samples.
- R4: power_o equals floor(energy_o / WINDOW), found by one trial quotient per clock.
- R5: rms_o equals floor(sqrt(power_o)), found by one trial root per clock.
- R6: db_o is the table word for rms_o: with h = round(2000*log10(rms_o)) for rms_o >= 1 and h = 0 for rms_o = 0, bits [15:8] hold h/100 (whole decibels) and bits [7:0] hold h mod 100 (hundredths).
- R7: done_o is high for exactly one cycle, in the cycle db_o first shows the new value; it rises q+r+7 clock edges after the edge that takes the window's last sample, where q is the quotient and r the root.
- R8: While holding a result, a cycle with sample_vld_i high and sample_i = 8'hFF starts a new window; that sample is not counted, other held-state samples and an 8'hFF without its valid strobe have no effect, and the old results stay at the outputs until the new window completes.
- R9: Samples arriving during the divide and square-root phases, 8'hFF included, are ignored and start no new window.
- R10: A full-scale window (every sample 255) gives energy 65025000, power 65025 and RMS 255 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 8 | Unsigned sample magnitude |
| sample_vld_i | input | 1 | Strobe marking sample_i as valid this cycle |
| energy_o | output | 32 | Sum of squares of the last completed window |
| power_o | output | 16 | Mean power, integer quotient |
| rms_o | output | 16 | Floor of the square root of the mean power |
| db_o | output | 16 | Decibel word, whole part in [15:8], hundredths in [7:0] |
| done_o | output | 1 | One-cycle flag: db_o holds a new value |

## Verification
The in-design assertions take for granted that the window length is nonzero and that sample_i is defined whenever sample_vld_i is high, so that the divisor never reaches zero and the quotient bound stays meaningful. The stimulus keeps to this: valid samples are always driven with defined values, strobe gaps are placed at random, and junk samples, 8'hFF among them, appear only while the block is computing or holding. The only restarts come from the explicit all-ones sequence issued once a result has been seen. Sample sets cover all-zero, full-scale, a small ramp and random magnitudes over narrow and full ranges.

// File: rtl/rssi_pkg.sv
// Package: shared state type and the decibel table word function.
// Assumes callers pass a non-negative RMS value that fits the table address.
package rssi_pkg;

    typedef enum logic [2:0] {
        ST_ACCUM,   // collecting samples
        ST_LDVS,    // capture divisor
        ST_LDVD,    // capture dividend
        ST_DIV,     // trial-quotient loop
        ST_LQ,      // capture quotient
        ST_SQRT,    // trial-root loop
        ST_HOLD     // results held
    } est_state_t;

    // Decibel word: whole dB in the upper byte, hundredths in the lower byte.
    function automatic logic [15:0] db_word(input int r);
        real v;
        int  h;
        if (r <= 0) begin
            return 16'd0;
        end
        v = 2000.0 * $log10(r);
        h = $rtoi(v + 0.5);
        return {8'(h / 100), 8'(h % 100)};
    endfunction

endpackage

// File: rtl/rssi_energy_acc.sv
// Energy accumulator: squares each accepted sample and sums it, counting
// accepted samples. Assumes en is only raised while the window is open.
module rssi_energy_acc #(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 32,
    parameter int WINDOW   = 1000,
    localparam int CNT_W   = $clog2(WINDOW + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [ACC_W-1:0]    sum_nxt,
    output logic [CNT_W-1:0]    cnt_q,
    output logic                last
);
    localparam int SQ_W = 2 * SAMPLE_W;

    logic [ACC_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [SQ_W-1:0]  sq;

    // Square of the incoming sample and the next running values.
    always_comb begin
        sq      = SQ_W'(sample) * SQ_W'(sample);
        sum_nxt = sum_q + ACC_W'(sq);
        cnt_nxt = cnt_q + CNT_W'(1);
        last    = en && (cnt_nxt >= CNT_W'(WINDOW));
    end

    // Running sum and sample count, cleared on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (en) begin
            sum_q <= sum_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // R2: the count never runs past the window.
    a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WINDOW));

    // R3: nothing moves the count while no sample is taken.
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/rssi_trial_div.sv
// Trial divider: one quotient trial per clock by repeated subtraction of the
// divisor from a running remainder. Assumes a nonzero divisor is loaded
// before the dividend and that step is held until fin.
module rssi_trial_div #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16,
    parameter int Q_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_dvs,
    input  logic [DVS_W-1:0] dvs_in,
    input  logic             load_dvd,
    input  logic [DVD_W-1:0] dvd_in,
    input  logic             step,
    output logic             fin,
    output logic [Q_W-1:0]   quot
);
    logic [DVS_W-1:0] dvs_q;
    logic [DVD_W-1:0] rem_q;

    // Loop ends once the remainder drops below the divisor.
    assign fin = rem_q < DVD_W'(dvs_q);

    // Divisor capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvs_q <= '0;
        end else if (load_dvs) begin
            dvs_q <= dvs_in;
        end
    end

    // Remainder and trial quotient; one subtraction per clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rem_q <= '0;
            quot  <= '0;
        end else if (load_dvd) begin
            rem_q <= dvd_in;
            quot  <= '0;
        end else if (step && !fin) begin
            rem_q <= rem_q - DVD_W'(dvs_q);
            quot  <= quot + Q_W'(1);
        end
    end

    // R4: a running trial always has a divisor to subtract.
    a_r4_divisor_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (dvs_q != '0));

endmodule

// File: rtl/rssi_trial_sqrt.sv
// Trial square root: raises a candidate root by one per clock, tracking its
// square incrementally, until the square exceeds the input; the floor root is
// then the candidate minus one. Assumes power_in is stable while stepping.
module rssi_trial_sqrt #(
    parameter int P_W  = 16,
    parameter int R_W  = 16,
    localparam int SQ_W = 2 * R_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           load,
    input  logic           step,
    input  logic [P_W-1:0] power_in,
    output logic           fin,
    output logic [R_W-1:0] root
);
    logic [R_W-1:0]  j_q;
    logic [SQ_W-1:0] sq_q;

    // Overshoot test and floor result.
    always_comb begin
        fin  = sq_q > SQ_W'(power_in);
        root = j_q - R_W'(1);
    end

    // Candidate root and its square; (j+1)^2 = j^2 + 2j + 1.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || load) begin
            j_q  <= '0;
            sq_q <= '0;
        end else if (step && !fin) begin
            j_q  <= j_q + R_W'(1);
            sq_q <= sq_q + SQ_W'({j_q, 1'b1});
        end
    end

    // R5/R10: the candidate never passes the largest root the input can need.
    a_r10_root_range: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (j_q <= R_W'(1 << ((P_W + 1) / 2))));

endmodule

// File: rtl/rssi_db_rom.sv
// Decibel table: one word per possible RMS value, filled at elaboration.
// Assumes the address is the RMS result truncated to ADDR_W bits.
module rssi_db_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    import rssi_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    typedef logic [DEPTH-1:0][DATA_W-1:0] tbl_t;

    function automatic tbl_t build_tbl();
        tbl_t t;
        for (int k = 0; k < DEPTH; k++) begin
            t[k] = DATA_W'(db_word(k));
        end
        return t;
    endfunction

    localparam tbl_t TABLE = build_tbl();

    // Table lookup; the caller registers the result.
    assign data = TABLE[addr];

endmodule

// File: rtl/rssi_power_est.sv
// RSSI power estimator top: sequences collection, divide, root and table
// lookup, and holds the results. Assumes WINDOW > 0 and that the sample is
// defined whenever its strobe is high.
module rssi_power_est #(
    parameter int SAMPLE_W = 8,
    parameter int WINDOW   = 1000,
    parameter int ACC_W    = 32,
    parameter int Q_W      = 16,
    parameter int DB_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                sample_vld_i,
    output logic [ACC_W-1:0]    energy_o,
    output logic [Q_W-1:0]      power_o,
    output logic [Q_W-1:0]      rms_o,
    output logic [DB_W-1:0]     db_o,
    output logic                done_o
);
    import rssi_pkg::*;

    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [SAMPLE_W-1:0] RESTART_CODE = '1;

    est_state_t       st;
    logic             restart;
    logic             acc_take;
    logic             acc_last;
    logic [ACC_W-1:0] acc_sum_nxt;
    logic [CNT_W-1:0] acc_cnt;
    logic             div_fin;
    logic [Q_W-1:0]   div_quot;
    logic             sq_fin;
    logic [Q_W-1:0]   sq_root;
    logic [DB_W-1:0]  rom_data;
    logic             done_pend;

    // Control decodes from the current state.
    always_comb begin
        restart  = (st == ST_HOLD) && sample_vld_i && (sample_i == RESTART_CODE);
        acc_take = (st == ST_ACCUM) && sample_vld_i;
    end

    rssi_energy_acc #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W),
        .WINDOW   (WINDOW)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .en      (acc_take),
        .sample  (sample_i),
        .sum_nxt (acc_sum_nxt),
        .cnt_q   (acc_cnt),
        .last    (acc_last)
    );

    rssi_trial_div #(
        .DVD_W (ACC_W),
        .DVS_W (Q_W),
        .Q_W   (Q_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .load_dvs (st == ST_LDVS),
        .dvs_in   (Q_W'(acc_cnt)),
        .load_dvd (st == ST_LDVD),
        .dvd_in   (energy_o),
        .step     (st == ST_DIV),
        .fin      (div_fin),
        .quot     (div_quot)
    );

    rssi_trial_sqrt #(
        .P_W (Q_W),
        .R_W (Q_W)
    ) u_sqrt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .load     (st == ST_LQ),
        .step     (st == ST_SQRT),
        .power_in (power_o),
        .fin      (sq_fin),
        .root     (sq_root)
    );

    rssi_db_rom #(
        .ADDR_W (SAMPLE_W),
        .DATA_W (DB_W)
    ) u_rom (
        .addr (rms_o[SAMPLE_W-1:0]),
        .data (rom_data)
    );

    // Sequencer and result registers; the table read is registered here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_ACCUM;
            energy_o  <= '0;
            power_o   <= '0;
            rms_o     <= '0;
            db_o      <= '0;
            done_o    <= 1'b0;
            done_pend <= 1'b0;
        end else begin
            db_o      <= rom_data;
            done_o    <= done_pend;
            done_pend <= 1'b0;
            case (st)
                ST_ACCUM: begin
                    if (acc_last) begin
                        energy_o <= acc_sum_nxt;
                        st       <= ST_LDVS;
                    end
                end
                ST_LDVS: st <= ST_LDVD;
                ST_LDVD: st <= ST_DIV;
                ST_DIV: begin
                    if (div_fin) begin
                        st <= ST_LQ;
                    end
                end
                ST_LQ: begin
                    power_o <= div_quot;
                    st      <= ST_SQRT;
                end
                ST_SQRT: begin
                    if (sq_fin) begin
                        rms_o     <= sq_root;
                        done_pend <= 1'b1;
                        st        <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (restart) begin
                        st <= ST_ACCUM;
                    end
                end
                default: st <= ST_ACCUM;
            endcase
        end
    end

    // R7: the done flag lasts a single cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: the captured quotient brackets the energy.
    a_r4_quotient_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SQRT && $past(st) == ST_LQ) |->
            ((64'(power_o) * 64'(WINDOW) <= 64'(energy_o)) &&
             (64'(energy_o) - 64'(power_o) * 64'(WINDOW) < 64'(WINDOW))));

    // R5: the held root is the floor square root of the held power.
    a_r5_root_floor: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((32'(rms_o) * 32'(rms_o) <= 32'(power_o)) &&
                    ((32'(rms_o) + 1) * (32'(rms_o) + 1) > 32'(power_o))));

    // R9: a busy phase never falls back to collecting.
    a_r9_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {ST_LDVS, ST_LDVD, ST_DIV, ST_LQ, ST_SQRT}) |=> (st != ST_ACCUM));

endmodule

// File: tb/tb_rssi_power_est.sv
// Bench: random and directed sample windows checked against bench-side models.
module tb_rssi_power_est;

    localparam int WIN = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sample = 8'd0;
    logic        vld = 1'b0;
    logic [31:0] energy;
    logic [15:0] power;
    logic [15:0] rms;
    logic [15:0] db;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rssi_power_est dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (sample),
        .sample_vld_i (vld),
        .energy_o     (energy),
        .power_o      (power),
        .rms_o        (rms),
        .db_o         (db),
        .done_o       (done)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint isqrt(input longint v);
        longint r = 0;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    function automatic longint exp_db(input longint r);
        int h;
        if (r == 0) return 0;
        h = $rtoi(2000.0 * $ln(real'(r)) / $ln(10.0) + 0.5);
        return longint'((h / 100) * 256 + (h % 100));
    endfunction

    function automatic logic [7:0] pick(input int kind, input int i);
        case (kind)
            0: return 8'd0;
            1: return 8'd255;
            2: return 8'($urandom_range(0, 40));
            3: return 8'($urandom_range(0, 255));
            default: return 8'(i % 16);
        endcase
    endfunction

    task automatic run_window(input int kind, input string name);
        longint e = 0;
        longint q;
        longint r;
        int n = 0;
        int lat = 0;
        while (n < WIN) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                vld = 1'b0;
                sample = 8'($urandom);
            end else begin
                vld = 1'b1;
                sample = pick(kind, n);
                e += longint'(sample) * longint'(sample);
                n++;
            end
        end
        @(posedge clk);
        q = e / WIN;
        r = isqrt(q);
        forever begin
            @(negedge clk);
            if (done) break;
            // R9 junk: all-ones with strobe early in the busy phase, else below it
            vld = 1'($urandom_range(0, 1));
            sample = (lat < 3) ? 8'hFF : 8'($urandom_range(0, 254));
            if (lat < 3) vld = 1'b1;
            lat++;
        end
        chk({"R2/R3/R9 energy ", name}, longint'(energy), e);
        chk({"R4 power ", name}, longint'(power), q);
        chk({"R5 rms ", name}, longint'(rms), r);
        chk({"R6 db ", name}, longint'(db), exp_db(r));
        chk({"R7 latency ", name}, longint'(lat), q + r + 7);
        if (kind == 1) begin
            chk("R10 full-scale energy", longint'(energy), 64'd65025000);
            chk("R10 full-scale rms", longint'(rms), 64'd255);
        end
        vld = 1'b0;
        @(negedge clk);
        chk({"R7 done width ", name}, longint'(done), 0);
    endtask

    task automatic restart_seq();
        longint held = longint'(energy);
        @(negedge clk);
        sample = 8'hFF; vld = 1'b0;      // R8: no strobe, no effect
        @(negedge clk);
        sample = 8'd7;  vld = 1'b1;      // R8: ignored while holding
        @(negedge clk);
        sample = 8'hFF; vld = 1'b1;      // R8: restart
        @(negedge clk);
        vld = 1'b0;
        chk("R8 results held after restart", longint'(energy), held);
        chk("R8 done low after restart", longint'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd51127));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset energy", longint'(energy), 0);
        chk("R1 reset power", longint'(power), 0);
        chk("R1 reset rms", longint'(rms), 0);
        chk("R1 reset db", longint'(db), 0);
        chk("R1 reset done", longint'(done), 0);
        run_window(0, "zeros");
        restart_seq();
        run_window(2, "small random");
        restart_seq();
        run_window(4, "ramp");
        restart_seq();
        run_window(3, "full-range random");
        restart_seq();
        run_window(1, "full scale");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule